// File: doc/BRIEF.md
# Latency-Compensated Streaming Output Buffer

This block terminates a fixed-latency processing pipeline that has no stall input and hands its results to a downstream stream port that uses a valid/ready handshake. Each result beat carries a data word, a channel number and start-of-packet and end-of-packet markers. Every valid beat that leaves the pipeline is written into internal storage: data and channel share one storage lane, and the two packet markers each have a lane of their own. All lanes share one pair of pointers and always advance together. The oldest stored beat is shown on the downstream port whenever storage holds anything, and it leaves storage on a cycle when the consumer signals ready.

Because beats already inside the pipeline cannot be stopped, the block pulls its upstream ready low early. A nearly-full flag rises once occupancy reaches a threshold that is at most the depth minus the pipeline latency. The upstream ready is the inverse of that flag. Every beat still in flight when ready falls therefore has a free slot waiting for it. A sticky error flag records any write that arrives while storage is full and no read frees a slot. It exists for verification only and is never expected to rise in a correctly configured system.

Top module: `stream_egress_buffer`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and on the first cycle after it, out_valid is 0, in_ready is 1, nearly_full is 0 and overflow_err is 0.
- R2: Beats accepted on the input leave on the output in arrival order, each with its data and channel unchanged.
- R3: Suppose an upstream source issues a beat only on cycles when in_ready is 1, and that beat reaches in_valid exactly LATENCY cycles later. Then storage never overflows under any downstream ready pattern, including ready held low indefinitely, and overflow_err stays 0.
- R4: While out_valid is 1 and out_ready is 0, the presented data, channel, sop and eop are held unchanged and out_valid stays 1 on the next cycle.
- R5: out_valid is 1 exactly when storage holds at least one beat. A beat is removed only on a cycle where out_valid and out_ready are both 1.
- R6: nearly_full is 1 exactly when occupancy is at least THRESHOLD (default DEPTH minus LATENCY), and in_ready is its inverse.
- R7: A cycle with an input write and an output read leaves occupancy unchanged, even when storage is full.
- R8: An input beat that arrives while storage is full, with no read on the same cycle, is discarded without disturbing stored beats. It sets overflow_err, which stays 1 until reset.
- R9: The sop and eop markers leave attached to the same beat they arrived with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pipeline result is valid this cycle |
| in_data | input | DATA_W | Pipeline result data |
| in_chan | input | CHAN_W | Channel number of the result |
| in_sop | input | 1 | Result starts a packet |
| in_eop | input | 1 | Result ends a packet |
| in_ready | output | 1 | Upstream may issue new work |
| out_valid | output | 1 | Head beat is presented |
| out_data | output | DATA_W | Head beat data |
| out_chan | output | CHAN_W | Head beat channel |
| out_sop | output | 1 | Head beat starts a packet |
| out_eop | output | 1 | Head beat ends a packet |
| out_ready | input | 1 | Downstream accepts the head beat this cycle |
| nearly_full | output | 1 | Occupancy has reached the threshold |
| overflow_err | output | 1 | Sticky: a beat was dropped because storage was full |

## Verification
The hardest case to reach is the last few slots filling at the same moment that in_ready falls, with a full pipeline's worth of beats still in flight. The bench reaches it with a model of an upstream source whose issued beats arrive exactly LATENCY cycles later. It alternates long stretches of downstream ready held low with pseudo-random ready patterns, so storage is driven to exactly full many times. Separate directed phases force a write into full storage with no read, and a write and read on the same cycle at full.

// File: rtl/egress_pkg.sv
package egress_pkg;

  // Width of a pointer that indexes depth entries.
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Width of an occupancy counter that can hold 0..depth.
  function automatic int unsigned occ_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/egress_ptr_ctrl.sv
module egress_ptr_ctrl
  import egress_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = addr_bits(DEPTH),
  localparam int unsigned OW   = occ_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [OW-1:0] occ,
  output logic          empty,
  output logic          overflow_hit
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [OW-1:0] FULL_OCC = OW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [OW-1:0] occ_q, occ_d;
  logic          full;
  logic          do_pop;
  logic          do_push;
  logic          ptr_ce;

  always_comb begin
    full         = (occ_q == FULL_OCC);
    empty        = (occ_q == '0);
    do_pop       = pop_req && !empty;
    do_push      = push_req && (!full || do_pop);
    overflow_hit = push_req && full && !do_pop;
    ptr_ce       = do_push || do_pop;

    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    occ_d    = occ_q;
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    end
    unique case ({do_push, do_pop})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else if (ptr_ce) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  assign wr_en   = do_push;
  assign wr_addr = wr_ptr_q;
  assign rd_addr = rd_ptr_q;
  assign occ     = occ_q;

endmodule

// File: rtl/egress_lane_mem.sv
module egress_lane_mem
  import egress_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_dat,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_dat
);

  logic [WIDTH-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_addr] <= wr_dat;
    end
  end

  assign rd_dat = store_q[rd_addr];

endmodule

// File: rtl/egress_fill_monitor.sv
module egress_fill_monitor
  import egress_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned THRESHOLD = 12,
  localparam int unsigned OW       = occ_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] occ,
  input  logic          overflow_hit,
  output logic          nearly_full,
  output logic          overflow_err
);

  localparam logic [OW-1:0] TH_OCC = OW'(THRESHOLD);

  logic err_q, err_d;

  always_comb begin
    nearly_full = (occ >= TH_OCC);
    err_d       = err_q || overflow_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (overflow_hit) begin
      err_q <= err_d;
    end
  end

  assign overflow_err = err_q;

endmodule

// File: rtl/stream_egress_buffer.sv
module stream_egress_buffer
  import egress_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CHAN_W    = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned LATENCY   = 4,
  parameter int unsigned THRESHOLD = DEPTH - LATENCY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CHAN_W-1:0] out_chan,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              out_ready,
  output logic              nearly_full,
  output logic              overflow_err
);

  localparam int unsigned AW     = addr_bits(DEPTH);
  localparam int unsigned OW     = occ_bits(DEPTH);
  localparam int unsigned MAIN_W = DATA_W + CHAN_W;
  localparam int unsigned N_MARK = 2;

  generate
    if (THRESHOLD + LATENCY > DEPTH || THRESHOLD == 0) begin : g_bad_cfg
      $error("stream_egress_buffer: THRESHOLD must lie in 1..DEPTH-LATENCY");
    end
  endgenerate

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [OW-1:0] occ;
  logic          empty;
  logic          overflow_hit;

  logic [MAIN_W-1:0] main_wr;
  logic [MAIN_W-1:0] main_rd;
  logic [N_MARK-1:0] mark_wr;
  logic [N_MARK-1:0] mark_rd;

  egress_ptr_ctrl #(
    .DEPTH (DEPTH)
  ) u_ptrs (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_req     (in_valid),
    .pop_req      (out_ready),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .rd_addr      (rd_addr),
    .occ          (occ),
    .empty        (empty),
    .overflow_hit (overflow_hit)
  );

  assign main_wr = {in_data, in_chan};

  egress_lane_mem #(
    .WIDTH (MAIN_W),
    .DEPTH (DEPTH)
  ) u_main_lane (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_dat  (main_wr),
    .rd_addr (rd_addr),
    .rd_dat  (main_rd)
  );

  // Marker lanes: bit 0 = start of packet, bit 1 = end of packet.
  assign mark_wr = {in_eop, in_sop};

  for (genvar m = 0; m < N_MARK; m++) begin : g_mark_lane
    egress_lane_mem #(
      .WIDTH (1),
      .DEPTH (DEPTH)
    ) u_mark (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_dat  (mark_wr[m]),
      .rd_addr (rd_addr),
      .rd_dat  (mark_rd[m])
    );
  end

  egress_fill_monitor #(
    .DEPTH     (DEPTH),
    .THRESHOLD (THRESHOLD)
  ) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .occ          (occ),
    .overflow_hit (overflow_hit),
    .nearly_full  (nearly_full),
    .overflow_err (overflow_err)
  );

  assign in_ready  = !nearly_full;
  assign out_valid = !empty;
  assign out_data  = main_rd[MAIN_W-1:CHAN_W];
  assign out_chan  = main_rd[CHAN_W-1:0];
  assign out_sop   = mark_rd[0];
  assign out_eop   = mark_rd[1];

endmodule

// File: rtl/stream_egress_buffer_chk.sv
module stream_egress_buffer_chk
  import egress_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CHAN_W    = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned THRESHOLD = 12,
  localparam int unsigned OW       = occ_bits(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [CHAN_W-1:0] out_chan,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_ready,
  input logic              nearly_full,
  input logic              overflow_err,
  input logic [OW-1:0]     occ
);

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));

  p_hold_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_chan) &&
       $stable(out_sop) && $stable(out_eop)));

  p_valid_tracks_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (occ != '0));

  p_idle_stays_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);

  p_flag_threshold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nearly_full == (occ >= OW'(THRESHOLD)));

  p_ready_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != nearly_full);

  p_swap_keeps_occ_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_valid && out_ready) |=> (occ == $past(occ)));

  p_ovf_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && occ == OW'(DEPTH) && !out_ready) |=> overflow_err);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

endmodule

bind stream_egress_buffer stream_egress_buffer_chk #(
  .DATA_W    (DATA_W),
  .CHAN_W    (CHAN_W),
  .DEPTH     (DEPTH),
  .THRESHOLD (THRESHOLD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_chan     (out_chan),
  .out_sop      (out_sop),
  .out_eop      (out_eop),
  .out_ready    (out_ready),
  .nearly_full  (nearly_full),
  .overflow_err (overflow_err),
  .occ          (occ)
);

// File: tb/stream_egress_buffer_test.sv
`timescale 1ns/1ps
module stream_egress_buffer_test;

  localparam int DW = 8;
  localparam int CW = 3;
  localparam int DP = 8;
  localparam int LT = 3;
  localparam int TH = DP - LT;
  localparam int BW = DW + CW + 2;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic [CW-1:0] in_chan;
  logic          in_sop;
  logic          in_eop;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_chan;
  logic          out_sop;
  logic          out_eop;
  logic          out_ready;
  logic          nearly_full;
  logic          overflow_err;

  stream_egress_buffer #(
    .DATA_W (DW), .CHAN_W (CW), .DEPTH (DP), .LATENCY (LT)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_data (in_data), .in_chan (in_chan),
    .in_sop (in_sop), .in_eop (in_eop), .in_ready (in_ready),
    .out_valid (out_valid), .out_data (out_data), .out_chan (out_chan),
    .out_sop (out_sop), .out_eop (out_eop), .out_ready (out_ready),
    .nearly_full (nearly_full), .overflow_err (overflow_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_vec;
  int n_bad;
  bit finished;

  // Reference queue, packed as {data, chan, eop, sop}.
  logic [BW-1:0] ref_q [DP];
  int ref_head;
  int ref_cnt;
  bit exp_ovf;
  int seq;
  bit hold_prev;
  logic [BW-1:0] prev_head;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [BW-1:0] make_beat(input int s);
    logic [DW-1:0] d;
    logic [CW-1:0] c;
    d = DW'(s * 37 + 5);
    c = CW'(s * 3 + s / 5);
    return {d, c, (s % 4 == 3), (s % 4 == 0)};
  endfunction

  task automatic ref_reset();
    ref_head = 0; ref_cnt = 0; exp_ovf = 0; hold_prev = 0;
  endtask

  // One clock cycle; entered just after a falling edge.
  task automatic cycle(input bit iv, input bit ordy, output bit rdy_seen);
    logic [BW-1:0] b;
    logic [BW-1:0] head;
    bit popped;
    b = make_beat(seq);
    in_valid  = iv;
    {in_data, in_chan, in_eop, in_sop} = b;
    out_ready = ordy;
    #1;
    rdy_seen = in_ready;
    head = {out_data, out_chan, out_eop, out_sop};
    chk(out_valid == (ref_cnt != 0), "R5 out_valid", out_valid, ref_cnt != 0);
    chk(nearly_full == (ref_cnt >= TH), "R6 nearly_full", nearly_full, ref_cnt >= TH);
    chk(in_ready == (ref_cnt < TH), "R6 in_ready", in_ready, ref_cnt < TH);
    chk(overflow_err == exp_ovf, "R8 overflow_err", overflow_err, exp_ovf);
    if (hold_prev && ref_cnt != 0)
      chk(head == prev_head, "R4 hold", head, prev_head);
    popped = 0;
    if (ref_cnt != 0) begin
      if (ordy) begin
        chk(head[BW-1:2] == ref_q[ref_head][BW-1:2], "R2 data/chan", head[BW-1:2],
            ref_q[ref_head][BW-1:2]);
        chk(head[1:0] == ref_q[ref_head][1:0], "R9 sop/eop", head[1:0], ref_q[ref_head][1:0]);
        ref_head = (ref_head + 1) % DP;
        ref_cnt--;
        popped = 1;
      end
    end
    hold_prev = (ref_cnt + (popped ? 1 : 0) != 0) && !ordy;
    prev_head = head;
    if (iv) begin
      if (ref_cnt < DP) begin
        ref_q[(ref_head + ref_cnt) % DP] = b;
        ref_cnt++;
      end else begin
        exp_ovf = 1;
      end
      seq++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 0; out_ready = 0;
    @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    chk(nearly_full == 0, "R1 nearly_full in reset", nearly_full, 0);
    chk(overflow_err == 0, "R1 overflow_err in reset", overflow_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_reset();
  endtask

  initial begin
    bit r;
    bit pipe [LT];
    bit want;
    logic [15:0] lfsr;
    n_vec = 0; n_bad = 0; finished = 0; seq = 0;
    in_valid = 0; in_data = '0; in_chan = '0; in_sop = 0; in_eop = 0; out_ready = 0;
    ref_reset();
    do_reset();

    // R1 after release, then R6 threshold sweep while filling (R5/R6 checked in cycle).
    for (int k = 0; k < DP; k++) cycle(1, 0, r);
    // R8: write into full storage with no read; beat dropped, flag sticks.
    cycle(1, 0, r);
    for (int k = 0; k < 3; k++) cycle(0, 0, r);
    // Drain all; contents must be the first DP beats only (R2, R8, R9).
    for (int k = 0; k < DP + 2; k++) cycle(0, 1, r);
    chk(out_valid == 0, "R8 dropped beat not stored", out_valid, 0);
    do_reset();
    chk(overflow_err == 0, "R8 cleared only by reset", overflow_err, 0);

    // R7: fill, then write and read on the same cycles at full.
    for (int k = 0; k < DP; k++) cycle(1, 0, r);
    for (int k = 0; k < 5; k++) cycle(1, 1, r);
    chk(nearly_full == 1, "R7 still full after swaps", nearly_full, 1);
    for (int k = 0; k < DP + 1; k++) cycle(0, 1, r);
    chk(overflow_err == 0, "R7 no overflow on swaps", overflow_err, 0);

    // R4: partial fill then long backpressure.
    for (int k = 0; k < 3; k++) cycle(1, 0, r);
    for (int k = 0; k < 6; k++) cycle(0, 0, r);
    for (int k = 0; k < 4; k++) cycle(0, 1, r);

    // R3: latency-LT source honouring in_ready, mixed downstream patterns.
    for (int k = 0; k < LT; k++) pipe[k] = 0;
    lfsr = 16'hACE1;
    for (int t = 0; t < 3000; t++) begin
      bit ordy;
      bit issue;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      want = (t % 97) < 90;
      if ((t / 150) % 3 == 0) ordy = 0;
      else if ((t / 150) % 3 == 1) ordy = lfsr[0] & lfsr[3];
      else ordy = lfsr[1] | lfsr[5];
      cycle(pipe[LT-1], ordy, r);
      issue = r && want;
      for (int k = LT - 1; k > 0; k--) pipe[k] = pipe[k-1];
      pipe[0] = issue;
    end
    for (int k = 0; k < LT; k++) cycle(pipe[LT-1-k], 1, r);
    for (int k = 0; k < DP + 2; k++) cycle(0, 1, r);
    chk(overflow_err == 0, "R3 no overflow under latency source", overflow_err, 0);
    chk(out_valid == 0, "R3 fully drained", out_valid, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule